// File: doc/BRIEF.md
# Two-Port Memory with Same-Address Collision Arbitration

This block is a clocked memory of 2048 words of 9 bits with two fully independent access ports, named left and right. Each port has an enable, a write strobe, an 11-bit address, write data and registered read data. Either port may read or write any word in any cycle. When both ports are enabled on the same address at the same time, the block detects a collision. It grants the word to the port that arrived first and reports busy to the other port. Any write the losing port attempts is blocked inside the block, so the memory never holds a half-decided value.

A build parameter selects one of two roles. In the arbitrating role the block makes the busy decision itself and drives active-low busy outputs. In the follower role the busy pins are inputs, supplied by an arbitrating instance that sits beside it in a wider word. Each input only blocks that port's writes, and the block's own busy outputs stay inactive. With both inputs tied high, a follower is a plain two-port memory.

Top module: `dpram_collision_guard`

## Requirements
- R1: Each port reads the word at its address one clock after it presents en=1, we=0, and that word is the last value written to it. Read data holds while the port is idle or writing, and is 0 after reset.
- R2: A collision exists exactly when both enables are 1 and the two addresses are equal. The write strobes play no part, so two reads of one word also collide.
- R3: When a collision starts, the port whose enable and address were already the same in the previous cycle wins. The opposite port's busy_n output goes to 0 on the next clock edge, and the winner's busy_n stays 1.
- R4: If both ports reach the matching address in the same cycle, the left port wins and the right port is the one reported busy.
- R5: A write by the losing port never changes the memory. This includes the first cycle of the collision, before busy_n is visible at the outputs.
- R6: Once the collision ends, because the addresses differ or an enable is 0, busy_n returns to 1 on the next edge. A write by the former loser in that ending cycle takes effect.
- R7: For as long as the collision lasts on the same address, the winner stays the winner and the loser stays blocked, even when the winner switches between reading and writing.
- R8: In the follower role, a busy input at 0 blocks that port's writes but not its reads, and both busy_n outputs stay at 1. With both inputs at 1, two same-cycle writes to one word are both performed, and the right port's data is the one kept.
- R9: After reset, both busy_n outputs are 1.
- R10: Accesses by the two ports to different addresses in the same cycle both complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| l_en | input | 1 | Left port access enable |
| l_we | input | 1 | Left port write strobe (1 = write, 0 = read) |
| l_addr | input | 11 | Left port word address |
| l_wdata | input | 9 | Left port write data |
| l_rdata | output | 9 | Left port registered read data |
| l_busy_in_n | input | 1 | Follower role: left write inhibit, active low; unused when arbitrating |
| l_busy_n | output | 1 | Left port lost a collision, active low, registered |
| r_en | input | 1 | Right port access enable |
| r_we | input | 1 | Right port write strobe (1 = write, 0 = read) |
| r_addr | input | 11 | Right port word address |
| r_wdata | input | 9 | Right port write data |
| r_rdata | output | 9 | Right port registered read data |
| r_busy_in_n | input | 1 | Follower role: right write inhibit, active low; unused when arbitrating |
| r_busy_n | output | 1 | Right port lost a collision, active low, registered |

## Verification
The assertion on who arrives first compares the current enable and address with their values one cycle earlier. It therefore assumes both enables are held at 0 while reset is asserted, and the bench keeps them low until reset is released. The assertions also assume that inputs change only between clock edges. The bench drives every input on the falling edge and reads outputs on the next falling edge. The follower checks assume the busy inputs are stable for a whole cycle, which the bench meets by changing them only together with the other stimulus.

// File: rtl/dpc_pkg.sv
// Shared types for the collision-guarded two-port memory.
// Assumes nothing beyond a single clock domain for all users.
package dpc_pkg;

    // Which port currently holds a contested word.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

endpackage

// File: rtl/dpc_match_arbiter.sv
// Same-address collision detector and first-arrival arbiter.
// The port whose enable and address were unchanged since the previous
// cycle wins a new match; a tie goes to the left port. Ownership is kept
// while both ports stay on the matched address. Loser flags are
// combinational, so a write in the first matching cycle is already gated;
// busy outputs are the registered, active-low copies.
// Assumes both enables are low while reset is asserted.
module dpc_match_arbiter
    import dpc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              match,
    output logic              l_lose,
    output logic              r_lose,
    output logic              l_busy_n,
    output logic              r_busy_n
);

    logic              prev_l_en;
    logic              prev_r_en;
    logic [ADDR_W-1:0] prev_l_addr;
    logic [ADDR_W-1:0] prev_r_addr;
    logic              l_held;
    logic              r_held;
    owner_e            owner_q;
    owner_e            owner_d;

    // Collision detect and "held since last cycle" terms.
    always_comb begin
        match  = l_en && r_en && (l_addr == r_addr);
        l_held = prev_l_en && (prev_l_addr == l_addr);
        r_held = prev_r_en && (prev_r_addr == r_addr);
    end

    // Pick the owner: keep it on a continuing match, else arbitrate afresh.
    always_comb begin
        if (!match) begin
            owner_d = OWN_NONE;
        end else if ((owner_q != OWN_NONE) && l_held && r_held) begin
            owner_d = owner_q;
        end else if (r_held && !l_held) begin
            owner_d = OWN_RIGHT;
        end else begin
            owner_d = OWN_LEFT;
        end
        l_lose = match && (owner_d == OWN_RIGHT);
        r_lose = match && (owner_d == OWN_LEFT);
    end

    // Remember each port's request and the owner for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_l_en   <= 1'b0;
            prev_r_en   <= 1'b0;
            prev_l_addr <= '0;
            prev_r_addr <= '0;
            owner_q     <= OWN_NONE;
        end else begin
            prev_l_en   <= l_en;
            prev_r_en   <= r_en;
            prev_l_addr <= l_addr;
            prev_r_addr <= r_addr;
            owner_q     <= owner_d;
        end
    end

    // Registered active-low busy flags toward the losing port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_busy_n <= 1'b1;
            r_busy_n <= 1'b1;
        end else begin
            l_busy_n <= !l_lose;
            r_busy_n <= !r_lose;
        end
    end

    // R2: never both ports flagged busy at once.
    a_r2_single_loser: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));

    // R6: busy drops on the edge after the match ends.
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> (l_busy_n && r_busy_n));

    // R3: a fresh match where only left was already in place flags right.
    a_r3_first_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !$past(match) && $past(l_en) && ($past(l_addr) == l_addr)
         && !($past(r_en) && ($past(r_addr) == r_addr))) |=> !r_busy_n);

    // R7: the loser stays the loser while the match holds on one address.
    a_r7_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (l_lose ##1 (match && $stable(l_addr) && $stable(r_addr))) |-> l_lose);

    a_r7_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_lose ##1 (match && $stable(l_addr) && $stable(r_addr))) |-> r_lose);

endmodule

// File: rtl/dpc_write_guard.sv
// Role-dependent write gating. Arbitrating role: a port's write is blocked
// when it lost the current match, and the arbiter's busy flags go out.
// Follower role: the external busy inputs block writes and the outputs
// stay inactive. Assumes the inputs are settled before the clock edge.
module dpc_write_guard #(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic l_en,
    input  logic l_we,
    input  logic r_en,
    input  logic r_we,
    input  logic l_lose,
    input  logic r_lose,
    input  logic l_arb_busy_n,
    input  logic r_arb_busy_n,
    input  logic l_busy_in_n,
    input  logic r_busy_in_n,
    output logic l_wr_go,
    output logic r_wr_go,
    output logic l_busy_out_n,
    output logic r_busy_out_n
);

    logic l_block;
    logic r_block;

    generate
        if (IS_MASTER) begin : g_master
            logic unused_busy_in;
            // Arbiter decides who is blocked and what is reported.
            assign l_block        = l_lose;
            assign r_block        = r_lose;
            assign l_busy_out_n   = l_arb_busy_n;
            assign r_busy_out_n   = r_arb_busy_n;
            assign unused_busy_in = l_busy_in_n ^ r_busy_in_n;
        end else begin : g_slave
            logic unused_arb;
            // External busy pins act purely as write inhibits.
            assign l_block      = !l_busy_in_n;
            assign r_block      = !r_busy_in_n;
            assign l_busy_out_n = 1'b1;
            assign r_busy_out_n = 1'b1;
            assign unused_arb   = ^{l_lose, r_lose, l_arb_busy_n, r_arb_busy_n};
        end
    endgenerate

    // Qualified write enables toward the storage array.
    always_comb begin
        l_wr_go = l_en && l_we && !l_block;
        r_wr_go = r_en && r_we && !r_block;
    end

endmodule

// File: rtl/dpc_dual_store.sv
// Two-port word array with registered read data (read on en && !we).
// Writes from both ports land in one cycle; on equal addresses the right
// port's data is kept. Assumes the write enables are already qualified.
module dpc_dual_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_rd,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_rd,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Array update; right port is applied last.
    always_ff @(posedge clk) begin
        if (l_wr) begin
            mem[l_addr] <= l_wdata;
        end
        if (r_wr) begin
            mem[r_addr] <= r_wdata;
        end
    end

    // Registered read data per port, held when not reading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_rdata <= '0;
            r_rdata <= '0;
        end else begin
            if (l_rd) begin
                l_rdata <= mem[l_addr];
            end
            if (r_rd) begin
                r_rdata <= mem[r_addr];
            end
        end
    end

endmodule

// File: rtl/dpram_collision_guard.sv
// Top: two-port memory with same-address collision arbitration and
// internal write blocking for the losing port. IS_MASTER selects the
// arbitrating role (busy computed and driven out) or the follower role
// (busy pins are write-inhibit inputs). Assumes enables low during reset.
module dpram_collision_guard #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 9,
    parameter bit IS_MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              l_busy_in_n,
    output logic              l_busy_n,
    input  logic              r_en,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    input  logic              r_busy_in_n,
    output logic              r_busy_n
);

    logic match;
    logic l_lose;
    logic r_lose;
    logic l_arb_busy_n;
    logic r_arb_busy_n;
    logic l_wr_go;
    logic r_wr_go;
    logic l_rd;
    logic r_rd;

    dpc_match_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .l_en     (l_en),
        .l_addr   (l_addr),
        .r_en     (r_en),
        .r_addr   (r_addr),
        .match    (match),
        .l_lose   (l_lose),
        .r_lose   (r_lose),
        .l_busy_n (l_arb_busy_n),
        .r_busy_n (r_arb_busy_n)
    );

    dpc_write_guard #(.IS_MASTER(IS_MASTER)) u_guard (
        .l_en         (l_en),
        .l_we         (l_we),
        .r_en         (r_en),
        .r_we         (r_we),
        .l_lose       (l_lose),
        .r_lose       (r_lose),
        .l_arb_busy_n (l_arb_busy_n),
        .r_arb_busy_n (r_arb_busy_n),
        .l_busy_in_n  (l_busy_in_n),
        .r_busy_in_n  (r_busy_in_n),
        .l_wr_go      (l_wr_go),
        .r_wr_go      (r_wr_go),
        .l_busy_out_n (l_busy_n),
        .r_busy_out_n (r_busy_n)
    );

    // Reads are never gated by busy.
    always_comb begin
        l_rd = l_en && !l_we;
        r_rd = r_en && !r_we;
    end

    dpc_dual_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_rd    (l_rd),
        .l_wr    (l_wr_go),
        .l_addr  (l_addr),
        .l_wdata (l_wdata),
        .l_rdata (l_rdata),
        .r_rd    (r_rd),
        .r_wr    (r_wr_go),
        .r_addr  (r_addr),
        .r_wdata (r_wdata),
        .r_rdata (r_rdata)
    );

    generate
        if (IS_MASTER) begin : g_chk_master
            // R5: the arbiter's loser never gets a write through.
            a_r5_left_blocked: assert property (@(posedge clk) disable iff (!rst_n)
                l_lose |-> !l_wr_go);
            a_r5_right_blocked: assert property (@(posedge clk) disable iff (!rst_n)
                r_lose |-> !r_wr_go);
        end else begin : g_chk_slave
            // R8: an active busy input blocks that port's write.
            a_r8_left_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
                !l_busy_in_n |-> !l_wr_go);
            a_r8_right_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
                !r_busy_in_n |-> !r_wr_go);
        end
    endgenerate

endmodule

// File: tb/dpram_collision_guard_bench.sv
// Bench: full-array sweep plus directed collision sequences on an
// arbitrating instance, and role checks on a follower instance.
module dpram_collision_guard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int DW = 9;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // Arbitrating instance stimulus
    logic          m_l_en = 0, m_l_we = 0, m_r_en = 0, m_r_we = 0;
    logic [AW-1:0] m_l_addr = 0, m_r_addr = 0;
    logic [DW-1:0] m_l_wdata = 0, m_r_wdata = 0;
    logic [DW-1:0] m_l_rdata, m_r_rdata;
    logic          m_l_busy_n, m_r_busy_n;

    // Follower instance stimulus
    logic          s_l_en = 0, s_l_we = 0, s_r_en = 0, s_r_we = 0;
    logic [AW-1:0] s_l_addr = 0, s_r_addr = 0;
    logic [DW-1:0] s_l_wdata = 0, s_r_wdata = 0;
    logic [DW-1:0] s_l_rdata, s_r_rdata;
    logic          s_l_busy_n, s_r_busy_n;
    logic          s_l_bin_n = 1, s_r_bin_n = 1;

    logic [DW-1:0] exp_m [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpram_collision_guard #(.ADDR_W(AW), .DATA_W(DW), .IS_MASTER(1'b1)) u_dpram_collision_guard (
        .clk(clk), .rst_n(rst_n),
        .l_en(m_l_en), .l_we(m_l_we), .l_addr(m_l_addr), .l_wdata(m_l_wdata),
        .l_rdata(m_l_rdata), .l_busy_in_n(1'b1), .l_busy_n(m_l_busy_n),
        .r_en(m_r_en), .r_we(m_r_we), .r_addr(m_r_addr), .r_wdata(m_r_wdata),
        .r_rdata(m_r_rdata), .r_busy_in_n(1'b1), .r_busy_n(m_r_busy_n)
    );

    dpram_collision_guard #(.ADDR_W(AW), .DATA_W(DW), .IS_MASTER(1'b0)) u_dpram_collision_guard_slave (
        .clk(clk), .rst_n(rst_n),
        .l_en(s_l_en), .l_we(s_l_we), .l_addr(s_l_addr), .l_wdata(s_l_wdata),
        .l_rdata(s_l_rdata), .l_busy_in_n(s_l_bin_n), .l_busy_n(s_l_busy_n),
        .r_en(s_r_en), .r_we(s_r_we), .r_addr(s_r_addr), .r_wdata(s_r_wdata),
        .r_rdata(s_r_rdata), .r_busy_in_n(s_r_bin_n), .r_busy_n(s_r_busy_n)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 37 + 5) % (1 << DW));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: outputs are read on the falling edge after the rising one.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic m_drive(input logic le, input logic lw, input int la, input int ld,
                           input logic re, input logic rw, input int ra, input int rd);
        m_l_en = le; m_l_we = lw; m_l_addr = AW'(la); m_l_wdata = DW'(ld);
        m_r_en = re; m_r_we = rw; m_r_addr = AW'(ra); m_r_wdata = DW'(rd);
    endtask

    task automatic s_drive(input logic le, input logic lw, input int la, input int ld,
                           input logic re, input logic rw, input int ra, input int rd);
        s_l_en = le; s_l_we = lw; s_l_addr = AW'(la); s_l_wdata = DW'(ld);
        s_r_en = re; s_r_we = rw; s_r_addr = AW'(ra); s_r_wdata = DW'(rd);
    endtask

    task automatic m_idle();
        m_drive(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        // R9 / R1: reset state
        chk("R9 l_busy_n reset", m_l_busy_n, 1);
        chk("R9 r_busy_n reset", m_r_busy_n, 1);
        chk("R1 l_rdata reset", m_l_rdata, 0);
        chk("R1 r_rdata reset", m_r_rdata, 0);
        chk("R9 slave busy reset", {s_l_busy_n, s_r_busy_n}, 3);
        rst_n = 1'b1;

        // R10: fill the array from both ports at disjoint addresses
        for (int a = 0; a < DEPTH / 2; a++) begin
            m_drive(1, 1, a, pat(a), 1, 1, a + DEPTH / 2, pat(a + DEPTH / 2));
            exp_m[a] = pat(a);
            exp_m[a + DEPTH / 2] = pat(a + DEPTH / 2);
            cyc();
            if (a % 256 == 0) chk("R10 no busy on disjoint writes", {m_l_busy_n, m_r_busy_n}, 3);
        end
        // R1 / R10: read back every word from both ports
        for (int i = 0; i < DEPTH; i++) begin
            m_drive(1, 0, i, 0, 1, 0, DEPTH - 1 - i, 0);
            cyc();
            chk("R1 left read", m_l_rdata, exp_m[i]);
            chk("R10 right read", m_r_rdata, exp_m[DEPTH - 1 - i]);
        end
        m_idle(); cyc();

        // R3 / R5 / R7 / R6: left arrives first at 100
        m_drive(1, 0, 100, 0, 0, 0, 0, 0); cyc();
        chk("R1 left read 100", m_l_rdata, exp_m[100]);
        m_drive(1, 0, 100, 0, 1, 1, 100, 'h0AA); cyc();
        chk("R3 right flagged", m_r_busy_n, 0);
        chk("R3 left not flagged", m_l_busy_n, 1);
        m_drive(1, 0, 100, 0, 1, 1, 100, 'h0AA); cyc();
        chk("R5 first-cycle write blocked", m_l_rdata, exp_m[100]);
        m_drive(1, 1, 100, 'h055, 1, 1, 100, 'h0AA); cyc();
        exp_m[100] = 'h055;
        chk("R7 right stays busy", m_r_busy_n, 0);
        m_drive(0, 0, 100, 0, 1, 1, 100, 'h0CC); cyc();
        exp_m[100] = 'h0CC;
        chk("R6 busy released", m_r_busy_n, 1);
        m_drive(1, 0, 100, 0, 0, 0, 0, 0); cyc();
        chk("R6 write after release", m_l_rdata, exp_m[100]);
        m_idle(); cyc();

        // R3 / R5: right arrives first at 200, left write blocked
        m_drive(0, 0, 0, 0, 1, 0, 200, 0); cyc();
        m_drive(1, 1, 200, 'h111, 1, 0, 200, 0); cyc();
        chk("R3 left flagged", m_l_busy_n, 0);
        chk("R3 right not flagged", m_r_busy_n, 1);
        m_drive(1, 1, 200, 'h111, 1, 0, 200, 0); cyc();
        chk("R5 left write blocked", m_r_rdata, exp_m[200]);
        m_idle(); cyc();
        chk("R6 left busy released", m_l_busy_n, 1);

        // R4: both arrive at 300 in the same cycle
        m_drive(1, 1, 300, 'h1A1, 1, 1, 300, 'h0B2); cyc();
        exp_m[300] = 'h1A1;
        chk("R4 tie right flagged", m_r_busy_n, 0);
        chk("R4 tie left not flagged", m_l_busy_n, 1);
        m_idle(); cyc();
        m_drive(1, 0, 300, 0, 0, 0, 0, 0); cyc();
        chk("R4 left data kept", m_l_rdata, exp_m[300]);

        // R6: right moves off the matched address, its write proceeds
        m_drive(1, 0, 400, 0, 0, 0, 0, 0); cyc();
        m_drive(1, 0, 400, 0, 1, 1, 400, 'h077); cyc();
        chk("R3 right flagged at 400", m_r_busy_n, 0);
        m_drive(1, 0, 400, 0, 1, 1, 401, 'h078); cyc();
        exp_m[401] = 'h078;
        chk("R6 busy clears on address change", m_r_busy_n, 1);
        chk("R5 400 unchanged", m_l_rdata, exp_m[400]);
        m_drive(1, 0, 401, 0, 0, 0, 0, 0); cyc();
        chk("R6 write to 401 landed", m_l_rdata, exp_m[401]);
        m_idle(); cyc();

        // R2: equal address with one port disabled is no collision
        m_drive(1, 1, 500, 'h099, 0, 0, 500, 0); cyc();
        exp_m[500] = 'h099;
        chk("R2 disabled port no busy", {m_l_busy_n, m_r_busy_n}, 3);
        m_idle(); cyc();
        // R2: two reads of one word still collide
        m_drive(1, 0, 600, 0, 1, 0, 600, 0); cyc();
        chk("R2 read-read collides", m_r_busy_n, 0);
        chk("R2 read-read left read", m_l_rdata, exp_m[600]);
        chk("R2 read-read right read", m_r_rdata, exp_m[600]);
        m_idle(); cyc();

        // R8: follower with busy inputs inactive, same-word writes
        s_drive(1, 1, 500, 'h011, 1, 1, 500, 'h022); cyc();
        chk("R8 slave busy outs inactive", {s_l_busy_n, s_r_busy_n}, 3);
        s_drive(1, 0, 500, 0, 0, 0, 0, 0); cyc();
        chk("R8 right data kept", s_l_rdata, 'h022);
        s_drive(1, 1, 501, 'h044, 0, 0, 0, 0); cyc();
        // R8: left inhibited by its busy input, right still writes
        s_l_bin_n = 1'b0;
        s_drive(1, 1, 501, 'h033, 1, 1, 502, 'h055); cyc();
        s_drive(1, 0, 501, 0, 1, 0, 502, 0); cyc();
        chk("R8 inhibited write blocked", s_l_rdata, 'h044);
        chk("R8 uninhibited write landed", s_r_rdata, 'h055);
        chk("R8 busy outs stay inactive", {s_l_busy_n, s_r_busy_n}, 3);
        s_l_bin_n = 1'b1;
        s_drive(0, 0, 0, 0, 0, 0, 0, 0); cyc();

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule